// File: doc/BRIEF.md
# Boot Overlay and Clock-Rate Latch

This block manages the start-up phase of a small processor system whose ROM is too slow for the full clock rate. After reset a single mode bit puts the system into boot mode. In boot mode the clock runs slowly, every read anywhere in the address space is served by the ROM, and every write goes to the RAM. Boot software can therefore copy each location onto itself (same source and destination address) and the ROM image ends up in the RAM underneath it. A ROM smaller than the address space repeats across the space, and software does not rely on those repeats.

When the copy is done, software writes to a control location. The external decode of that location drives the clear strobe. At the end of that CPU cycle the mode bit clears. ROM is then disabled, RAM serves reads and writes, and the clock divider reloads with its fast value, all at the same cycle boundary. Only a new reset brings boot mode back. The block contains the clock divider that produces the CPU clock and exposes the reload value it is using. It does not contain the processor or the memories.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While reset is low, and afterwards until the mode is cleared, the block is in boot mode: rom_oe_n=0, ram_oe_n=1, div_load=SLOW_HALF-1, cpu_clk=0.
- R2: In boot mode a read at any address is served by ROM. rom_addr equals the low ROM_AW bits of addr, so addresses that differ only above bit ROM_AW-1 return the same ROM byte.
- R3: ram_we_n is low exactly while cpu_clk is high during a write cycle (rw=0), in either mode. It is never low during a read cycle (rw=1).
- R4: Exactly one of rom_oe_n and ram_oe_n is low at every clock edge outside reset.
- R5: clr_sel asserted during a read cycle has no effect, and the block stays in boot mode.
- R6: A write cycle with clr_sel=1 leaves the mode unchanged while that cycle runs. The mode changes on the clock edge where cpu_clk falls at the end of that cycle.
- R7: After the mode is cleared, reads are served by RAM (ram_oe_n=0, rom_oe_n=1). Further clear writes have no effect until the next reset.
- R8: The cpu_clk period is 2*SLOW_HALF clock periods in boot mode and 2*FAST_HALF after the mode is cleared. The first CPU cycle after the clear is already fast.
- R9: div_load is SLOW_HALF-1 in boot mode and FAST_HALF-1 in run mode, and it changes on the same edge as the output enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; enters boot mode |
| addr | input | ADDR_W | CPU address, held for a whole CPU cycle |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| clr_sel | input | 1 | Decode of the control location that clears boot mode |
| cpu_clk | output | 1 | Divided CPU clock; a CPU cycle ends when it falls |
| rom_addr | output | ROM_AW | ROM address lines (low bits of addr) |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| div_load | output | CNT_W | Reload value of the clock divider for the current mode |

## Verification
The assertions assume that addr, rw and clr_sel change only just after a falling cpu_clk, so that they hold one value for a whole CPU cycle. The mode-change and read-clear properties compare rw across the cycle-end edge on that basis. The bench plays the role of the CPU. It drives a new access only a moment after it sees cpu_clk fall and holds that access until the next fall, which keeps the stimulus within this assumption. Its memory model returns ROM or RAM data only according to the enables the block produces.

// File: rtl/boot_overlay_pkg.sv
// Shared types and helpers for the boot overlay controller.
// Assumes: a single mode bit; boot mode is the reset state.
package boot_overlay_pkg;

    // Operating mode of the overlay latch
    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_BOOT = 1'b1
    } ovl_mode_t;

    // Convert a half-period length in clocks to a down-counter reload value
    function automatic int unsigned half_to_load(input int unsigned half);
        return (half == 0) ? 0 : half - 1;
    endfunction

endpackage

// File: rtl/ovl_mode_latch.sv
// Mode latch: one flip-flop that holds boot or run mode.
// Does: enters boot on reset and clears only at a CPU cycle end, on a
// write cycle that selects the control location.
// Assumes: rw and clr_sel are stable for the whole CPU cycle.
module ovl_mode_latch
    import boot_overlay_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cyc_end,
    input  logic      rw,
    input  logic      clr_sel,
    output ovl_mode_t mode_q,
    output ovl_mode_t mode_d
);

    logic clear_hit;

    // Qualify the clear: boot mode, write cycle, control location, cycle end
    always_comb begin
        clear_hit = (mode_q == MODE_BOOT) && cyc_end && clr_sel && !rw;
    end

    // Next mode: run once cleared, otherwise hold
    always_comb begin
        mode_d = clear_hit ? MODE_RUN : mode_q;
    end

    // Mode flip-flop with reset into boot mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_BOOT;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/ovl_rate_div.sv
// Loadable clock divider for the CPU clock.
// Does: counts a half period down from the reload value, then toggles the
// CPU clock. The reload value comes from the mode that will hold after
// this edge, so a mode change and the rate change share one boundary.
// Assumes: SLOW_HALF and FAST_HALF are at least 1 and fit in CNT_W bits.
module ovl_rate_div
    import boot_overlay_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned SLOW_HALF = 4,
    parameter int unsigned FAST_HALF = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ovl_mode_t        mode_q,
    input  ovl_mode_t        mode_d,
    output logic             phi,
    output logic             cyc_end,
    output logic [CNT_W-1:0] load_cur
);

    localparam logic [CNT_W-1:0] SlowLoad = CNT_W'(half_to_load(SLOW_HALF));
    localparam logic [CNT_W-1:0] FastLoad = CNT_W'(half_to_load(FAST_HALF));

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_next;
    logic             half_done;

    // Reload for the upcoming half period and for the present mode
    always_comb begin
        load_next = (mode_d == MODE_BOOT) ? SlowLoad : FastLoad;
        load_cur  = (mode_q == MODE_BOOT) ? SlowLoad : FastLoad;
    end

    // Terminal count and end of a full CPU cycle (high phase finishing)
    always_comb begin
        half_done = (cnt_q == '0);
        cyc_end   = half_done && phi;
    end

    // Half-period down-counter and CPU clock phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= SlowLoad;
            phi   <= 1'b0;
        end else if (half_done) begin
            cnt_q <= load_next;
            phi   <= ~phi;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ovl_mem_steer.sv
// Memory steering for the overlay.
// Does: drives the ROM address and the ROM/RAM enables from the mode. ROM
// answers every read in boot mode (it repeats across the space) and RAM
// answers in run mode. Writes strobe RAM during the high CPU phase.
// Assumes: ROM_AW <= ADDR_W.
module ovl_mem_steer
    import boot_overlay_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned ROM_AW = 8
) (
    input  ovl_mode_t         mode_q,
    input  logic              phi,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_oe_n,
    output logic              ram_oe_n,
    output logic              ram_we_n
);

    // ROM sees only its own address lines, so it repeats across the space
    always_comb begin
        rom_addr = addr[ROM_AW-1:0];
    end

    // Upper address bits play no part in selection
    generate
        if (ROM_AW < ADDR_W) begin : g_hi
            logic unused_addr_hi;
            always_comb unused_addr_hi = ^addr[ADDR_W-1:ROM_AW];
        end
    endgenerate

    // Enables: the mode bit drives ROM and its complement drives RAM
    always_comb begin
        rom_oe_n = (mode_q != MODE_BOOT);
        ram_oe_n = (mode_q == MODE_BOOT);
        ram_we_n = !(phi && !rw);
    end

endmodule

// File: rtl/boot_overlay_ctrl.sv
// Boot overlay controller (top).
// Does: ties the mode latch, the clock divider and the memory steering
// together. Reset puts the block in boot mode (slow clock, ROM reads, RAM
// writes). A clear write switches to run mode (fast clock, RAM only) at
// the end of that CPU cycle.
// Assumes: addr, rw and clr_sel change only just after cpu_clk falls.
module boot_overlay_ctrl
    import boot_overlay_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ROM_AW    = 8,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned SLOW_HALF = 4,
    parameter int unsigned FAST_HALF = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              clr_sel,
    output logic              cpu_clk,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_oe_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [CNT_W-1:0]  div_load
);

    ovl_mode_t mode_q;
    ovl_mode_t mode_d;
    logic      cyc_end;

    ovl_mode_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_end (cyc_end),
        .rw      (rw),
        .clr_sel (clr_sel),
        .mode_q  (mode_q),
        .mode_d  (mode_d)
    );

    ovl_rate_div #(
        .CNT_W     (CNT_W),
        .SLOW_HALF (SLOW_HALF),
        .FAST_HALF (FAST_HALF)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .mode_d   (mode_d),
        .phi      (cpu_clk),
        .cyc_end  (cyc_end),
        .load_cur (div_load)
    );

    ovl_mem_steer #(
        .ADDR_W (ADDR_W),
        .ROM_AW (ROM_AW)
    ) u_steer (
        .mode_q   (mode_q),
        .phi      (cpu_clk),
        .rw       (rw),
        .addr     (addr),
        .rom_addr (rom_addr),
        .rom_oe_n (rom_oe_n),
        .ram_oe_n (ram_oe_n),
        .ram_we_n (ram_we_n)
    );

endmodule

// File: rtl/boot_overlay_chk.sv
// Checker for the boot overlay controller, bound to the top.
// Assumes: inputs change only just after a falling cpu_clk.
module boot_overlay_chk #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ROM_AW    = 8,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned SLOW_HALF = 4,
    parameter int unsigned FAST_HALF = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rw,
    input logic              clr_sel,
    input logic              cpu_clk,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_oe_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic [CNT_W-1:0]  div_load
);

    // R4: exactly one memory drives the data bus
    assert_one_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rom_oe_n, ~ram_oe_n}) == 1);

    // R3: no RAM write strobe on a read cycle
    assert_no_we_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rw |-> ram_we_n);

    // R3: write strobe only in the high CPU phase
    assert_we_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> cpu_clk);

    // R6: mode leaves boot only where a CPU cycle ends
    assert_switch_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_oe_n) |-> $fell(cpu_clk));

    // R5: a read cycle never changes the mode
    assert_read_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_clk) && $past(rw)) |-> $stable(rom_oe_n));

    // R7: run mode is kept until reset
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |=> !ram_oe_n);

    // R9: reload value follows the mode
    assert_load_boot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> (div_load == CNT_W'(SLOW_HALF - 1)));

    assert_load_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> (div_load == CNT_W'(FAST_HALF - 1)));

    // R2: ROM address lines follow the low address bits
    assert_rom_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr == addr[ROM_AW-1:0]);

    logic unused_chk;
    always_comb unused_chk = clr_sel;

endmodule

bind boot_overlay_ctrl boot_overlay_chk #(
    .ADDR_W    (ADDR_W),
    .ROM_AW    (ROM_AW),
    .CNT_W     (CNT_W),
    .SLOW_HALF (SLOW_HALF),
    .FAST_HALF (FAST_HALF)
) u_chk (.*);

// File: tb/boot_overlay_ctrl_tb.sv
// Bench for the boot overlay controller. It acts as the CPU and models the
// ROM and RAM, then walks a vector table and runs directed tests.
module boot_overlay_ctrl_tb;

    localparam int ADDR_W    = 10;
    localparam int ROM_AW    = 8;
    localparam int CNT_W     = 4;
    localparam int SLOW_HALF = 4;
    localparam int FAST_HALF = 1;
    localparam int NVEC      = 15;

    // kind: 0 = write (no data check), 1 = expect ROM byte of addr, 2 = expect lit
    typedef struct packed {
        logic              rw;
        logic              clr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wd;
        logic [1:0]        kind;
        logic [7:0]        lit;
        logic              boot_after;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 10'h005, 8'hA5, 2'd0, 8'h00, 1'b1}, // R3 write in boot
        '{1'b1, 1'b0, 10'h005, 8'h00, 2'd1, 8'h00, 1'b1}, // R2 read ROM
        '{1'b1, 1'b0, 10'h105, 8'h00, 2'd1, 8'h00, 1'b1}, // R2 repeat image
        '{1'b0, 1'b0, 10'h3FF, 8'h5A, 2'd0, 8'h00, 1'b1},
        '{1'b1, 1'b0, 10'h3FF, 8'h00, 2'd1, 8'h00, 1'b1}, // R2 top address
        '{1'b1, 1'b1, 10'h200, 8'h00, 2'd1, 8'h00, 1'b1}, // R5 clear on read
        '{1'b1, 1'b0, 10'h010, 8'h00, 2'd1, 8'h00, 1'b1}, // R5 still boot
        '{1'b0, 1'b0, 10'h010, 8'hC3, 2'd0, 8'h00, 1'b1},
        '{1'b0, 1'b1, 10'h300, 8'h77, 2'd0, 8'h00, 1'b0}, // R6 clear write
        '{1'b1, 1'b0, 10'h005, 8'h00, 2'd2, 8'hA5, 1'b0}, // R7 RAM data
        '{1'b1, 1'b0, 10'h105, 8'h00, 2'd2, 8'h00, 1'b0}, // R7 no repeat
        '{1'b1, 1'b0, 10'h3FF, 8'h00, 2'd2, 8'h5A, 1'b0},
        '{1'b1, 1'b0, 10'h300, 8'h00, 2'd2, 8'h77, 1'b0}, // R3 clear write hit RAM
        '{1'b0, 1'b1, 10'h010, 8'h99, 2'd0, 8'h00, 1'b0}, // R7 second clear
        '{1'b1, 1'b0, 10'h010, 8'h00, 2'd2, 8'h99, 1'b0}  // R7 RAM updated
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              rw = 1'b1;
    logic              clr_sel = 1'b0;
    logic [7:0]        wdata = '0;
    logic              cpu_clk;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_oe_n;
    logic              ram_oe_n;
    logic              ram_we_n;
    logic [CNT_W-1:0]  div_load;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] ram [1 << ADDR_W];

    always #5 clk = ~clk;

    boot_overlay_ctrl #(
        .ADDR_W (ADDR_W), .ROM_AW (ROM_AW), .CNT_W (CNT_W),
        .SLOW_HALF (SLOW_HALF), .FAST_HALF (FAST_HALF)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .rw (rw), .clr_sel (clr_sel),
        .cpu_clk (cpu_clk), .rom_addr (rom_addr), .rom_oe_n (rom_oe_n),
        .ram_oe_n (ram_oe_n), .ram_we_n (ram_we_n), .div_load (div_load)
    );

    // ROM contents, computed
    function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
        return 8'((int'(a) * 37 + 11) & 8'hFF);
    endfunction

    // Data bus as the memories would drive it
    function automatic logic [7:0] bus_data();
        if (!rom_oe_n) return rom_byte(rom_addr);
        if (!ram_oe_n) return ram[addr];
        return 8'hEE;
    endfunction

    // RAM model: write while the strobe is low
    always @(negedge clk) begin
        if (!ram_we_n) ram[addr] <= wdata;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // One CPU cycle; starts just after a cycle end, returns just after the next
    task automatic cpu_cycle(input vec_t v, input logic boot_before);
        addr = v.addr; rw = v.rw; clr_sel = v.clr; wdata = v.wd;
        @(posedge cpu_clk); #1;
        check("R6 mode held during cycle", {31'b0, rom_oe_n}, {31'b0, !boot_before});
        check("R3 write strobe", {31'b0, ram_we_n}, {31'b0, v.rw});
        if (v.kind == 2'd1)
            check("R2 ROM read", {24'b0, bus_data()}, {24'b0, rom_byte(v.addr[ROM_AW-1:0])});
        else if (v.kind == 2'd2)
            check("R7 RAM read", {24'b0, bus_data()}, {24'b0, v.lit});
        @(negedge cpu_clk); #1;
        check("R6 mode after cycle end", {31'b0, rom_oe_n}, {31'b0, !v.boot_after});
        check("R9 load value", {28'b0, div_load},
              v.boot_after ? 32'(SLOW_HALF - 1) : 32'(FAST_HALF - 1));
    endtask

    // Measure one cpu_clk period in master clocks, then realign to a cycle end
    task automatic measure(output int clocks);
        realtime t0;
        addr = '0; rw = 1'b1; clr_sel = 1'b0;
        @(posedge cpu_clk); t0 = $realtime;
        @(posedge cpu_clk); clocks = int'(($realtime - t0) / 10.0);
        @(negedge cpu_clk); #1;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R1 rom_oe_n"}, {31'b0, rom_oe_n}, 32'd0);
        check({tag, " R1 ram_oe_n"}, {31'b0, ram_oe_n}, 32'd1);
        check({tag, " R1 cpu_clk"}, {31'b0, cpu_clk}, 32'd0);
        check({tag, " R1 div_load"}, {28'b0, div_load}, 32'(SLOW_HALF - 1));
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int per;
        logic boot;
        for (int i = 0; i < (1 << ADDR_W); i++) ram[i] = 8'h00;
        repeat (3) @(posedge clk); #1;
        check_reset_state("in reset");
        rst_n = 1'b1;
        check_reset_state("after reset");

        measure(per);
        check("R8 slow period", 32'(per), 32'(2 * SLOW_HALF));

        boot = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            cpu_cycle(VECS[i], boot);
            boot = VECS[i].boot_after;
        end

        measure(per);
        check("R8 fast period", 32'(per), 32'(2 * FAST_HALF));
        check("R7 ROM disabled", {31'b0, rom_oe_n}, 32'd1);
        check("R4 one enable", {30'b0, rom_oe_n, ram_oe_n}, 32'd2);

        // Reset again: back to boot mode with slow clock
        @(posedge clk); #1; rst_n = 1'b0;
        repeat (2) @(posedge clk); #1;
        check_reset_state("re-reset");
        rst_n = 1'b1;
        measure(per);
        check("R8 slow again after reset", 32'(per), 32'(2 * SLOW_HALF));
        cpu_cycle('{1'b1, 1'b0, 10'h005, 8'h00, 2'd1, 8'h00, 1'b1}, 1'b1);
        summary();
    end

endmodule